// File: doc/BRIEF.md
# PCI Power-Management Capability Registers

This block holds the configuration-space state of a PCI power-management capability: the two-bit device power state, the wake (PME) enable bit, the sticky wake status bit, the read-only no-soft-reset flag and the constant capability word. Software reaches the control/status halfword through a configuration access port. Each access carries a dword index, a byte offset within the dword, a byte count and 32 bits of write data, where the first data byte sits in bits [7:0]. A device-side wake request is turned into a one-cycle PME pulse, but only when the device is parked in D3 with wake enabled.

Every write to the control dword compares the decoded power state before and after the write. When the decoded class changes, a one-cycle event goes out carrying the old and new classes, so the power controller can start its sequence. The request port is a valid/ready pair whose ready is held high: every valid cycle is one access and there is no back-pressure. Read data comes back through a valid strobe one cycle after the read is taken.

Top module: `pm_cap_regs`

## Requirements
- R1: A synchronous active-low reset sets power state to D0, clears PME enable and PME status, drives `pme_pulse`, `chg_valid` and `rd_valid` low, and loads the no-soft-reset flag from `nsr_cfg`.
- R2: A read of dword 1 returns, one cycle later with `rd_valid` high, the halfword {status at bit 15, enable at bit 8, no-soft-reset at bit 3, power state at bits [1:0], all other bits 0} zero-extended to 32 bits. A read of any other dword returns 0.
- R3: `cap_word` is 16'h0002 when PME_SUPPORT is 0. When PME_SUPPORT is 1 it is 16'hC802, which adds wake support from D0 (bit 11), D3hot (bit 14) and D3cold (bit 15).
- R4: A write to dword 1 at offset 0, of any size, loads the power state from data bits [1:0] and leaves the other low-byte bits unchanged. All four encodings are stored and read back.
- R5: The high byte is taken from data bits [15:8] for a 2- or 4-byte write at offset 0, and from data bits [7:0] for a 1-byte write at offset 1. Bit 0 of that byte sets or clears PME enable. A 1 in bit 7 of that byte clears PME status, and a 0 there leaves it unchanged.
- R6: Writes at offsets 2 or 3, a 2- or 4-byte write at offset 1, and writes to any dword other than 1 change no register.
- R7: The no-soft-reset bit cannot be changed by any write.
- R8: A wake request while the state is 3 (D3) and enable is 1 sets PME status and raises `pme_pulse` for one cycle after the request edge. In any other state it changes nothing and no pulse is produced.
- R9: When a wake request that qualifies and a status-clearing write fall in the same cycle, status ends at 1 and the pulse is still produced.
- R10: After a write to dword 1 whose decoded class differs before and after (class code 0 = D0, 3 = D3, 1 = unsupported for encodings 1 and 2), `chg_valid` is high for one cycle with `chg_old` and `chg_new`. No event fires when the class is unchanged, including a move between encodings 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nsr_cfg | input | 1 | No-soft-reset value sampled during reset |
| cfg_valid | input | 1 | Access request valid |
| cfg_ready | output | 1 | Always high, so there is no back-pressure |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_idx | input | IDX_W | Dword index within the capability |
| cfg_offset | input | 2 | Starting byte offset in the dword |
| cfg_size | input | 3 | Byte count (1, 2 or 4) |
| cfg_wdata | input | 32 | Write data, first byte in [7:0] |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| cap_word | output | 16 | Capability halfword |
| wake_req | input | 1 | Device wake request |
| pme_pulse | output | 1 | One-cycle PME indication |
| pwr_state | output | 2 | Current stored power state |
| chg_valid | output | 1 | Power-class change event |
| chg_old | output | 2 | Class before the write |
| chg_new | output | 2 | Class after the write |

## Verification
The hardest case to reach from the ports is a qualifying wake request that lands in the same edge as a write clearing PME status. Reaching it takes three steps: a write that moves the device into D3 with enable set, a wake that makes status sticky, and then the clearing write driven in the same cycle as a second wake. The bench also sweeps every offset, size and data pattern starting from that sticky-status state, so each write path is seen both clearing and keeping the bit. It sweeps all sixteen ordered pairs of power encodings to cover every event and non-event case.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int ST_LSB   = 0;
  localparam int NSR_BIT  = 3;
  localparam int EN_BIT   = 8;
  localparam int STS_BIT  = 15;
  localparam logic [1:0] ENC_D0 = 2'd0;
  localparam logic [1:0] ENC_D3 = 2'd3;

  localparam logic [15:0] CAP_VERSION = 16'h0002;
  localparam logic [15:0] CAP_WAKE_SUPPORT = 16'hC800;

  typedef enum logic [1:0] {
    CLS_D0    = 2'd0,
    CLS_UNSUP = 2'd1,
    CLS_D3    = 2'd3
  } pwr_class_t;

  function automatic pwr_class_t classify(input logic [1:0] enc);
    if (enc == ENC_D0)      return CLS_D0;
    else if (enc == ENC_D3) return CLS_D3;
    else                    return CLS_UNSUP;
  endfunction
endpackage

// File: rtl/pm_wr_decode.sv
module pm_wr_decode #(
  parameter int IDX_W    = 6,
  parameter int CTRL_IDX = 1
) (
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [1:0]       acc_off,
  input  logic [2:0]       acc_size,
  input  logic [31:0]      acc_wdata,
  output logic             wr_hit,
  output logic             lo_we,
  output logic [1:0]       lo_state,
  output logic             hi_we,
  output logic             hi_en,
  output logic             hi_clr
);
  logic       hit_wide;
  logic       hit_byte1;
  logic [7:0] hi_byte;
  logic       unused_wdata;

  assign wr_hit    = acc_valid && acc_write && (acc_idx == IDX_W'(CTRL_IDX));
  assign hit_wide  = (acc_off == 2'd0) && ((acc_size == 3'd2) || (acc_size == 3'd4));
  assign hit_byte1 = (acc_off == 2'd1) && (acc_size == 3'd1);

  assign lo_we    = wr_hit && (acc_off == 2'd0);
  assign lo_state = acc_wdata[1:0];
  assign hi_we    = wr_hit && (hit_wide || hit_byte1);
  assign hi_byte  = hit_wide ? acc_wdata[15:8] : acc_wdata[7:0];
  assign hi_en    = hi_byte[0];
  assign hi_clr   = hi_byte[7];

  assign unused_wdata = ^{acc_wdata};
endmodule

// File: rtl/pm_ctrl_regs.sv
module pm_ctrl_regs
  import pm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nsr_cfg,
  input  logic        lo_we,
  input  logic [1:0]  lo_state,
  input  logic        hi_we,
  input  logic        hi_en,
  input  logic        hi_clr,
  input  logic        wake_req,
  output logic [1:0]  state_q,
  output logic [1:0]  state_d,
  output logic [15:0] csr_word,
  output logic        pme_pulse
);
  logic en_q, sts_q, nsr_q;
  logic en_d, sts_d;
  logic wake_hit;

  assign wake_hit = wake_req && (state_q == ENC_D3) && en_q;
  assign state_d  = lo_we ? lo_state : state_q;
  assign en_d     = hi_we ? hi_en : en_q;

  always_comb begin
    sts_d = sts_q;
    if (hi_we && hi_clr) sts_d = 1'b0;
    if (wake_hit)        sts_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ENC_D0;
      en_q      <= 1'b0;
      sts_q     <= 1'b0;
      nsr_q     <= nsr_cfg;
      pme_pulse <= 1'b0;
    end else begin
      state_q   <= state_d;
      en_q      <= en_d;
      sts_q     <= sts_d;
      pme_pulse <= wake_hit;
    end
  end

  always_comb begin
    csr_word = '0;
    csr_word[ST_LSB +: 2] = state_q;
    csr_word[NSR_BIT]     = nsr_q;
    csr_word[EN_BIT]      = en_q;
    csr_word[STS_BIT]     = sts_q;
  end
endmodule

// File: rtl/pm_change_evt.sv
module pm_change_evt
  import pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [1:0] enc_before,
  input  logic [1:0] enc_after,
  output logic       chg_valid,
  output logic [1:0] chg_old,
  output logic [1:0] chg_new
);
  pwr_class_t cls_before, cls_after;

  assign cls_before = classify(enc_before);
  assign cls_after  = classify(enc_after);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_valid <= 1'b0;
      chg_old   <= 2'd0;
      chg_new   <= 2'd0;
    end else begin
      chg_valid <= wr_hit && (cls_before != cls_after);
      if (wr_hit) begin
        chg_old <= cls_before;
        chg_new <= cls_after;
      end
    end
  end
endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
  import pm_pkg::*;
#(
  parameter int IDX_W       = 6,
  parameter int CTRL_IDX    = 1,
  parameter bit PME_SUPPORT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nsr_cfg,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic             cfg_write,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [1:0]       cfg_offset,
  input  logic [2:0]       cfg_size,
  input  logic [31:0]      cfg_wdata,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  output logic [15:0]      cap_word,
  input  logic             wake_req,
  output logic             pme_pulse,
  output logic [1:0]       pwr_state,
  output logic             chg_valid,
  output logic [1:0]       chg_old,
  output logic [1:0]       chg_new
);
  logic        wr_hit, lo_we, hi_we, hi_en, hi_clr;
  logic [1:0]  lo_state, state_q, state_d;
  logic [15:0] csr_word;

  assign cfg_ready = 1'b1;
  assign pwr_state = state_q;

  generate
    if (PME_SUPPORT) begin : g_wake_cap
      assign cap_word = CAP_VERSION | CAP_WAKE_SUPPORT;
    end else begin : g_plain_cap
      assign cap_word = CAP_VERSION;
    end
  endgenerate

  pm_wr_decode #(.IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX)) u_dec (
    .acc_valid(cfg_valid), .acc_write(cfg_write), .acc_idx(cfg_idx),
    .acc_off(cfg_offset), .acc_size(cfg_size), .acc_wdata(cfg_wdata),
    .wr_hit(wr_hit), .lo_we(lo_we), .lo_state(lo_state),
    .hi_we(hi_we), .hi_en(hi_en), .hi_clr(hi_clr)
  );

  pm_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .nsr_cfg(nsr_cfg),
    .lo_we(lo_we), .lo_state(lo_state), .hi_we(hi_we), .hi_en(hi_en),
    .hi_clr(hi_clr), .wake_req(wake_req), .state_q(state_q),
    .state_d(state_d), .csr_word(csr_word), .pme_pulse(pme_pulse)
  );

  pm_change_evt u_evt (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit),
    .enc_before(state_q), .enc_after(state_d),
    .chg_valid(chg_valid), .chg_old(chg_old), .chg_new(chg_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cfg_valid && !cfg_write;
      if (cfg_valid && !cfg_write)
        rd_data <= (cfg_idx == IDX_W'(CTRL_IDX)) ? {16'h0000, csr_word} : 32'h0;
    end
  end
endmodule

// File: rtl/pm_cap_regs_chk.sv
module pm_cap_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_valid,
  input logic        cfg_write,
  input logic        wake_req,
  input logic [1:0]  pwr_state,
  input logic        pme_pulse,
  input logic [15:0] csr_word,
  input logic        rd_valid,
  input logic        chg_valid,
  input logic [1:0]  chg_old,
  input logic [1:0]  chg_new
);
  assert_pulse_from_d3_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pme_pulse |-> ($past(wake_req) && $past(pwr_state) == 2'd3));

  assert_pulse_sets_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pme_pulse |-> csr_word[15]);

  assert_wake_wins_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && pwr_state == 2'd3 && csr_word[8]) |=> csr_word[15]);

  assert_nsr_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(csr_word[3]));

  assert_event_differs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> (chg_old != chg_new));

  assert_event_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> ($past(cfg_valid) && $past(cfg_write)));

  assert_read_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(cfg_valid) && !$past(cfg_write)));
endmodule

bind pm_cap_regs pm_cap_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
  .wake_req(wake_req), .pwr_state(pwr_state), .pme_pulse(pme_pulse),
  .csr_word(csr_word), .rd_valid(rd_valid), .chg_valid(chg_valid),
  .chg_old(chg_old), .chg_new(chg_new)
);

// File: tb/tb_pm_cap_regs.sv
`timescale 1ns/1ps
module tb_pm_cap_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nsr_cfg = 1'b1;
  logic        cfg_valid = 1'b0, cfg_write = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [1:0]  cfg_offset = '0;
  logic [2:0]  cfg_size = 3'd1;
  logic [31:0] cfg_wdata = '0;
  logic        wake_req = 1'b0;
  logic        cfg_ready, rd_valid, pme_pulse, chg_valid;
  logic [31:0] rd_data;
  logic [15:0] cap_word, cap_word_np;
  logic [1:0]  pwr_state, chg_old, chg_new;
  logic        np_ready, np_rdv, np_pme, np_chg;
  logic [31:0] np_rd;
  logic [1:0]  np_st, np_o, np_n;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [1:0] m_state;
  logic       m_en, m_sts;

  always #5 clk = ~clk;

  pm_cap_regs dut (
    .clk(clk), .rst_n(rst_n), .nsr_cfg(nsr_cfg), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_write(cfg_write), .cfg_idx(cfg_idx),
    .cfg_offset(cfg_offset), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .cap_word(cap_word),
    .wake_req(wake_req), .pme_pulse(pme_pulse), .pwr_state(pwr_state),
    .chg_valid(chg_valid), .chg_old(chg_old), .chg_new(chg_new)
  );

  pm_cap_regs #(.PME_SUPPORT(1'b0)) dut_nopme (
    .clk(clk), .rst_n(rst_n), .nsr_cfg(1'b0), .cfg_valid(1'b0),
    .cfg_ready(np_ready), .cfg_write(1'b0), .cfg_idx(6'd0),
    .cfg_offset(2'd0), .cfg_size(3'd1), .cfg_wdata(32'h0),
    .rd_valid(np_rdv), .rd_data(np_rd), .cap_word(cap_word_np),
    .wake_req(1'b0), .pme_pulse(np_pme), .pwr_state(np_st),
    .chg_valid(np_chg), .chg_old(np_o), .chg_new(np_n)
  );

  function automatic logic [1:0] cls(input logic [1:0] s);
    return (s == 2'd0) ? 2'd0 : (s == 2'd3) ? 2'd3 : 2'd1;
  endfunction

  function automatic logic [31:0] m_word();
    return {16'h0, m_sts, 6'b0, m_en, 4'b0, nsr_cfg, 1'b0, m_state};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access cycle; model updated from the requirements
  task automatic step(input bit v, input bit wr, input logic [5:0] idx, input logic [1:0] off,
                      input logic [2:0] sz, input logic [31:0] d, input bit wk, input string req);
    logic [1:0] old_c, new_c;
    bit lo, hi, hit, ev;
    logic [7:0] hb;
    logic [31:0] rexp;
    @(negedge clk);
    cfg_valid = v; cfg_write = wr; cfg_idx = idx; cfg_offset = off;
    cfg_size = sz; cfg_wdata = d; wake_req = wk;
    rexp = (idx == 6'd1) ? m_word() : 32'h0;
    old_c = cls(m_state);
    lo  = v && wr && idx == 6'd1 && off == 2'd0;
    hi  = v && wr && idx == 6'd1 &&
          ((off == 2'd0 && (sz == 3'd2 || sz == 3'd4)) || (off == 2'd1 && sz == 3'd1));
    hb  = (off == 2'd0) ? d[15:8] : d[7:0];
    hit = wk && m_state == 2'd3 && m_en;
    if (hi && hb[7]) m_sts = 1'b0;
    if (hit) m_sts = 1'b1;
    if (hi) m_en = hb[0];
    if (lo) m_state = d[1:0];
    new_c = cls(m_state);
    ev = v && wr && idx == 6'd1 && old_c != new_c;
    @(posedge clk); #1;
    chk(pme_pulse == hit, {req, " R8 pme_pulse"}, pme_pulse, hit);
    chk(chg_valid == ev, {req, " R10 chg_valid"}, chg_valid, ev);
    if (ev) chk({chg_old, chg_new} == {old_c, new_c}, {req, " R10 old/new"},
                {chg_old, chg_new}, {old_c, new_c});
    if (v && !wr) chk(rd_valid && rd_data == rexp, {req, " R2 read"}, rd_data, rexp);
    cfg_valid = 1'b0; wake_req = 1'b0;
  endtask

  task automatic rd_check(input string req);
    step(1, 0, 6'd1, 2'd0, 3'd4, 32'h0, 0, req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h0000_8103; pats[1] = 32'h0000_0000;
    pats[2] = 32'h1234_80FE; pats[3] = 32'hFFFF_01FD;
    m_state = 2'd0; m_en = 1'b0; m_sts = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!pme_pulse && !chg_valid && !rd_valid && pwr_state == 2'd0, "R1 reset outputs",
        {pme_pulse, chg_valid, rd_valid, pwr_state}, 0);
    @(negedge clk); rst_n = 1'b1;
    rd_check("R1 reset word");
    step(1, 0, 6'd0, 2'd0, 3'd4, 32'h0, 0, "R2 dword0");
    step(1, 0, 6'd7, 2'd0, 3'd4, 32'h0, 0, "R2 dword7");
    chk(cap_word == 16'hC802, "R3 cap with wake", cap_word, 16'hC802);
    chk(cap_word_np == 16'h0002, "R3 cap plain", cap_word_np, 16'h0002);
    chk(cfg_ready, "R2 ready", cfg_ready, 1);

    // all ordered pairs of encodings, junk in bits [7:2] (R4, R7, R10)
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        step(1, 1, 6'd1, 2'd0, 3'd1, 32'h0000_00F4 | a, 0, "R4 set a");
        step(1, 1, 6'd1, 2'd0, 3'd1, 32'h0000_00B0 | b, 0, "R10 pair");
        rd_check("R4 R7 readback");
        chk(pwr_state == 2'(b), "R4 pwr_state", pwr_state, b);
      end

    // wake in every state and enable setting (R8)
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 2; e++) begin
        step(1, 1, 6'd1, 2'd0, 3'd2, 32'h0000_8000 | (e << 8) | s, 0, "R8 setup");
        step(0, 0, 6'd0, 2'd0, 3'd1, 32'h0, 1, "R8 wake");
        rd_check("R8 status");
      end

    // every offset, size and pattern from a sticky-status state (R5, R6)
    for (int o = 0; o < 4; o++)
      for (int z = 0; z < 3; z++)
        for (int p = 0; p < 4; p++) begin
          step(1, 1, 6'd1, 2'd0, 3'd2, 32'h0000_0103, 0, "R5 prep");
          step(0, 0, 6'd0, 2'd0, 3'd1, 32'h0, 1, "R5 prep wake");
          step(1, 1, 6'd1, 2'(o), 3'(1 << z), pats[p], 0, "R5 R6 write");
          rd_check("R5 R6 readback");
          step(1, 1, 6'd2, 2'(o), 3'(1 << z), ~pats[p], 0, "R6 other dword");
          rd_check("R6 unchanged");
        end

    // wake and clearing write in the same cycle (R9)
    step(1, 1, 6'd1, 2'd0, 3'd2, 32'h0000_0103, 0, "R9 prep");
    step(0, 0, 6'd0, 2'd0, 3'd1, 32'h0, 1, "R9 prep wake");
    step(1, 1, 6'd1, 2'd1, 3'd1, 32'h0000_0081, 1, "R9 clear+wake");
    rd_check("R9 status kept");
    step(1, 1, 6'd1, 2'd0, 3'd4, 32'h0000_8003, 1, "R9 clear+disable+wake");
    rd_check("R9 status kept2");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule